// File: doc/BRIEF.md
# I2C Target with Byte Register Space

This block is a target-only I2C port that lets a host controller read and write a bank of 128 byte-wide control locations. SCL and SDA are sampled with the system clock. START and STOP conditions are recovered from the sampled lines. The block answers one 7-bit device address, whose lowest bit comes from a strap input. SDA is never driven high: the block only pulls it low, for acknowledge bits and for zero bits of read data.

A write transaction first loads an internal 7-bit location pointer from the initial data byte. Each following byte is stored at the pointer, and the pointer then advances. A read transaction returns bytes starting at the current pointer, and the pointer advances after each byte. The usual random-access read is a write that carries only the pointer byte, followed by a repeated START and a read. Some locations have reserved bits, some are read-only and some are fully reserved. Writes to those bits have no effect, and reserved bits read back as zero.

Top module: `cfgbus_i2c_target`

## Requirements
- R1: The block acknowledges device address 0100000 when `addr_strap` is 0 and 0100001 when it is 1. The eighth address bit selects read (1) or write (0).
- R2: Any other address is not acknowledged, including the general-call address 0000000. The rest of that transaction changes no register.
- R3: The first data byte of a write is loaded into the pointer. Its bit 7 is ignored.
- R4: Every later write data byte is acknowledged and stored at the pointer, and the pointer then increases by one.
- R5: A read returns data MSB first, starting at the current pointer, and the pointer increases by one after each byte sent.
- R6: Locations 0x00 to 0x3F are fully writable bytes and reset to 0x00.
- R7: At locations 0x40 to 0x5F only bits 7:4 are writable. Bits 3:0 are reserved and always read 0.
- R8: Locations 0x60 to 0x6F are read-only and return 0xC0 plus the low four address bits. Writes to them have no effect.
- R9: Locations 0x70 to 0x7F are reserved. They read 0x00 and ignore writes.
- R10: The pointer wraps from 0x7F to 0x00, on writes and on reads.
- R11: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A repeated START at any point returns the block to address reception.
- R12: When the controller NACKs a read byte, the transfer ends and SDA stays released until the next START.
- R13: `sda_pull_low` is 0 after reset and in the cycle after a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strap | input | 1 | Selects the lowest bit of the device address |
| scl_in | input | 1 | Sensed SCL line |
| sda_in | input | 1 | Sensed SDA line (wired-AND bus level) |
| sda_pull_low | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
Single-byte write-then-read pairs cover every region of the map: fully writable, half-reserved, read-only and reserved. This separates correct storage from wrong masking. Bursts in each direction distinguish a pointer that advances per byte from one that stays put. Transactions started at 0x7F show that the pointer wraps rather than saturates. Foreign and general-call addresses, strap changes, a pointer byte with bit 7 set, and a NACKed read followed by more clocking separate address decoding, MSB masking and SDA release.

// File: rtl/cfgbus_i2c_pkg.sv
package cfgbus_i2c_pkg;
   localparam int unsigned FULL_END = 64;
   localparam int unsigned HALF_END = 96;
   localparam int unsigned RO_END   = 112;

   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_WDATA, ST_ACK, ST_RDATA, ST_RACK
   } tgt_state_t;

   function automatic logic [7:0] wr_mask_f(input int unsigned a);
      if (a < FULL_END)      return 8'hFF;
      else if (a < HALF_END) return 8'hF0;
      else                   return 8'h00;
   endfunction

   function automatic logic [7:0] ro_value_f(input int unsigned a);
      if (a >= HALF_END && a < RO_END) return {4'hC, 4'(a)};
      else                             return 8'h00;
   endfunction
endpackage

// File: rtl/cfgbus_line_sampler.sv
module cfgbus_line_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_rise,
   output logic scl_fall,
   output logic sda_level,
   output logic start_det,
   output logic stop_det
);
   logic [SYNC_STAGES-1:0] scl_q, sda_q;
   logic scl_p, sda_p, scl_s, sda_s;

   generate
      if (SYNC_STAGES < 2) begin : g_bad
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= '1;
         sda_q <= '1;
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_q <= {scl_q[SYNC_STAGES-2:0], scl_in};
         sda_q <= {sda_q[SYNC_STAGES-2:0], sda_in};
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_s     = scl_q[SYNC_STAGES-1];
   assign sda_s     = sda_q[SYNC_STAGES-1];
   assign sda_level = sda_s;
   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_det = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/cfgbus_reg_bank.sv
module cfgbus_reg_bank
   import cfgbus_i2c_pkg::*;
#(
   parameter int REG_DEPTH = 128,
   localparam int PTR_W = $clog2(REG_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [PTR_W-1:0] wr_addr,
   input  logic [7:0]       wr_data,
   input  logic [PTR_W-1:0] rd_addr,
   output logic [7:0]       rd_data
);
   logic [7:0] mem [REG_DEPTH];
   logic [7:0] wmask;

   assign wmask = wr_mask_f(int'(wr_addr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < REG_DEPTH; i++) mem[i] <= 8'h00;
      end else if (wr_en) begin
         mem[wr_addr] <= (mem[wr_addr] & ~wmask) | (wr_data & wmask);
      end
   end

   assign rd_data = (mem[rd_addr] & wr_mask_f(int'(rd_addr))) | ro_value_f(int'(rd_addr));

   // R8 / R9: a write aimed at a read-only or reserved location leaves it untouched
   a_r8_locked_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wmask == 8'h00) |=> mem[$past(wr_addr)] == $past(mem[wr_addr]));
endmodule

// File: rtl/cfgbus_i2c_fsm.sv
module cfgbus_i2c_fsm
   import cfgbus_i2c_pkg::*;
#(
   parameter logic [5:0] DEV_ADDR_HI = 6'b010000,
   parameter int         REG_DEPTH   = 128,
   localparam int        PTR_W       = $clog2(REG_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             addr_strap,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             sda_level,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic [7:0]       rd_data,
   output logic             wr_en,
   output logic [PTR_W-1:0] ptr,
   output logic [7:0]       wr_data,
   output logic             sda_pull_low
);
   tgt_state_t st;
   logic [3:0] cnt;
   logic [7:0] shreg, txb;
   logic       rw, first;
   logic [6:0] my_addr;
   logic       byte_done;

   assign my_addr   = {DEV_ADDR_HI, addr_strap};
   assign byte_done = scl_fall && cnt == 4'd8;
   assign wr_en     = (st == ST_WDATA) && byte_done && !first && !start_det && !stop_det;
   assign wr_data   = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; cnt <= '0; shreg <= '0; txb <= '0;
         rw <= 1'b0; first <= 1'b0; ptr <= '0; sda_pull_low <= 1'b0;
      end else if (start_det) begin
         st <= ST_ADDR; cnt <= '0; first <= 1'b1; sda_pull_low <= 1'b0;
      end else if (stop_det) begin
         st <= ST_IDLE; sda_pull_low <= 1'b0;
      end else begin
         unique case (st)
            ST_ADDR, ST_WDATA: begin
               if (scl_rise && cnt < 4'd8) begin
                  shreg <= {shreg[6:0], sda_level};
                  cnt   <= cnt + 4'd1;
               end else if (byte_done) begin
                  if (st == ST_ADDR) begin
                     if (shreg[7:1] == my_addr) begin
                        sda_pull_low <= 1'b1; rw <= shreg[0]; st <= ST_ACK;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end else begin
                     sda_pull_low <= 1'b1; st <= ST_ACK;
                     if (first) begin
                        ptr <= shreg[PTR_W-1:0]; first <= 1'b0;
                     end else begin
                        ptr <= ptr + 1'b1;
                     end
                  end
               end
            end
            ST_ACK: if (scl_fall) begin
               cnt <= '0;
               if (rw) begin
                  txb <= rd_data; sda_pull_low <= ~rd_data[7]; st <= ST_RDATA;
               end else begin
                  sda_pull_low <= 1'b0; st <= ST_WDATA;
               end
            end
            ST_RDATA: begin
               if (scl_rise) cnt <= cnt + 4'd1;
               else if (scl_fall) begin
                  if (cnt == 4'd8) begin
                     sda_pull_low <= 1'b0; ptr <= ptr + 1'b1; st <= ST_RACK;
                  end else begin
                     txb <= {txb[6:0], 1'b0}; sda_pull_low <= ~txb[6];
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise && sda_level) st <= ST_IDLE;
               else if (scl_fall) begin
                  txb <= rd_data; sda_pull_low <= ~rd_data[7]; cnt <= '0; st <= ST_RDATA;
               end
            end
            default: ;
         endcase
      end
   end

   // R11: a START always brings the block back to address reception
   a_r11_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> st == ST_ADDR);
   // R2: a foreign address leaves SDA released and the block idle
   a_r2_no_ack_foreign: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ADDR && byte_done && shreg[7:1] != my_addr) |=> (!sda_pull_low && st == ST_IDLE));
   // R4: each stored byte moves the pointer forward by one
   a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ptr == $past(ptr) + 1'b1);
   // R12: a NACK on a read byte ends the transfer with SDA released
   a_r12_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RACK && scl_rise && sda_level && !stop_det && !start_det) |=> (st == ST_IDLE && !sda_pull_low));
   // R13: SDA is released after a STOP
   a_r13_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_pull_low);
endmodule

// File: rtl/cfgbus_i2c_target.sv
module cfgbus_i2c_target #(
   parameter logic [5:0] DEV_ADDR_HI = 6'b010000,
   parameter int         REG_DEPTH   = 128,
   parameter int         SYNC_STAGES = 2,
   localparam int        PTR_W       = $clog2(REG_DEPTH)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic addr_strap,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_pull_low
);
   generate
      if (REG_DEPTH != 128) begin : g_depth_chk
         $error("REG_DEPTH must be 128: the pointer is seven bits wide");
      end
   endgenerate

   logic scl_rise, scl_fall, sda_level, start_det, stop_det;
   logic wr_en;
   logic [PTR_W-1:0] ptr;
   logic [7:0] wr_data, rd_data;

   cfgbus_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_level(sda_level),
      .start_det(start_det), .stop_det(stop_det));

   cfgbus_i2c_fsm #(.DEV_ADDR_HI(DEV_ADDR_HI), .REG_DEPTH(REG_DEPTH)) u_fsm (
      .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_level(sda_level),
      .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data),
      .wr_en(wr_en), .ptr(ptr), .wr_data(wr_data), .sda_pull_low(sda_pull_low));

   cfgbus_reg_bank #(.REG_DEPTH(REG_DEPTH)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr),
      .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data));
endmodule

// File: tb/cfgbus_i2c_target_tb.sv
module cfgbus_i2c_target_tb_top;
   localparam int Q = 10;
   localparam logic [14:0] VEC [8] = '{
      {7'h00, 8'h5A}, {7'h3F, 8'hC3}, {7'h40, 8'h9E}, {7'h5F, 8'h0F},
      {7'h60, 8'hFF}, {7'h6A, 8'h12}, {7'h70, 8'hAB}, {7'h7E, 8'h77}};

   logic clk = 1'b0, rst_n = 1'b0, strap = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
   logic sda_pull_low, sda_bus;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;
   assign sda_bus = m_sda & ~sda_pull_low;

   cfgbus_i2c_target dut_i (.clk(clk), .rst_n(rst_n), .addr_strap(strap),
      .scl_in(m_scl), .sda_in(sda_bus), .sda_pull_low(sda_pull_low));

   function automatic logic [7:0] model(input logic [6:0] a, input logic [7:0] d);
      if (a < 7'h40)      return d;
      else if (a < 7'h60) return d & 8'hF0;
      else if (a < 7'h70) return {4'hC, a[3:0]};
      else                return 8'h00;
   endfunction

   function automatic string region(input logic [6:0] a);
      if (a < 7'h40)      return "R6";
      else if (a < 7'h60) return "R7";
      else if (a < 7'h70) return "R8";
      else                return "R9";
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(2);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(2);
      end
      m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); ack = !sda_bus; wq(Q); m_scl = 1'b0; wq(2);
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] b);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(Q); m_scl = 1'b1; wq(Q); b[i] = sda_bus; wq(Q); m_scl = 1'b0; wq(2);
      end
      m_sda = !give_ack; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(2); m_sda = 1'b1;
   endtask

   function automatic logic [7:0] dev(input bit rd);
      return {6'b010000, strap, rd};
   endfunction

   task automatic wr1(input logic [7:0] p, input logic [7:0] d);
      bit a;
      bus_start(); send_byte(dev(0), a); send_byte(p, a); send_byte(d, a); bus_stop();
   endtask

   task automatic set_ptr_read(input logic [7:0] p, input int n, output logic [7:0] d0, output logic [7:0] d1);
      bit a;
      bus_start(); send_byte(dev(0), a); send_byte(p, a);
      bus_start(); send_byte(dev(1), a);
      recv_byte(n > 1, d0);
      d1 = 8'h00;
      if (n > 1) recv_byte(1'b0, d1);
      bus_stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] d0, d1, d2;
      bit a;
      bit seen;
      wq(5);
      chk(sda_pull_low == 1'b0, "R13 reset release", {7'h0, sda_pull_low}, 8'h00);
      rst_n = 1'b1; wq(5);

      // table: write one location, read it back (R6 R7 R8 R9, R1 ack with strap 0)
      foreach (VEC[k]) begin
         wr1({1'b0, VEC[k][14:8]}, VEC[k][7:0]);
         set_ptr_read({1'b0, VEC[k][14:8]}, 1, d0, d1);
         chk(d0 == model(VEC[k][14:8], VEC[k][7:0]), region(VEC[k][14:8]), d0,
             model(VEC[k][14:8], VEC[k][7:0]));
      end

      // R2: foreign and general-call addresses are not acknowledged
      bus_start(); send_byte({7'b0100001, 1'b0}, a); bus_stop();
      chk(!a, "R2 foreign address acked", {7'h0, a}, 8'h00);
      bus_start(); send_byte(8'h00, a);
      chk(!a, "R2 general call acked", {7'h0, a}, 8'h00);
      send_byte(8'h05, a); send_byte(8'h99, a); bus_stop();
      set_ptr_read(8'h05, 1, d0, d1);
      chk(d0 == 8'h00, "R2 foreign write changed register", d0, 8'h00);

      // R1: strap selects the low address bit
      strap = 1'b1; wq(5);
      bus_start(); send_byte(8'h42, a); bus_stop();
      chk(a, "R1 strap-high address not acked", {7'h0, a}, 8'h01);
      bus_start(); send_byte(8'h40, a); bus_stop();
      chk(!a, "R1 strap-low address acked with strap high", {7'h0, a}, 8'h00);

      // R4 / R5: burst write then burst read
      bus_start(); send_byte(dev(0), a); send_byte(8'h10, a);
      send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
      chk(a, "R4 data byte not acked", {7'h0, a}, 8'h01);
      bus_stop();
      bus_start(); send_byte(dev(0), a); send_byte(8'h10, a);
      bus_start(); send_byte(dev(1), a);
      recv_byte(1'b1, d0); recv_byte(1'b1, d1); recv_byte(1'b0, d2); bus_stop();
      chk(d0 == 8'h11, "R5 burst byte 0", d0, 8'h11);
      chk(d1 == 8'h22, "R4 R5 burst byte 1", d1, 8'h22);
      chk(d2 == 8'h33, "R4 R5 burst byte 2", d2, 8'h33);

      // R3: bit 7 of the pointer byte is ignored
      wr1(8'h81, 8'h3C);
      set_ptr_read(8'h01, 1, d0, d1);
      chk(d0 == 8'h3C, "R3 pointer MSB not ignored", d0, 8'h3C);

      // R10: wrap on write and on read
      bus_start(); send_byte(dev(0), a); send_byte(8'h7F, a);
      send_byte(8'hEE, a); send_byte(8'hA5, a); bus_stop();
      set_ptr_read(8'h7F, 2, d0, d1);
      chk(d0 == 8'h00, "R10 R9 reserved 0x7F", d0, 8'h00);
      chk(d1 == 8'hA5, "R10 wrapped write and read", d1, 8'hA5);

      // R11: repeated START in the middle of a data byte restarts address reception
      bus_start(); send_byte(dev(0), a); send_byte(8'h20, a);
      m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(2);
      bus_start(); send_byte(dev(0), a);
      chk(a, "R11 address after repeated START", {7'h0, a}, 8'h01);
      bus_stop();

      // R12: after a NACK SDA stays released while the controller keeps clocking
      bus_start(); send_byte(dev(0), a); send_byte(8'h60, a);
      bus_start(); send_byte(dev(1), a);
      recv_byte(1'b0, d0);
      seen = 1'b0;
      for (int i = 0; i < 9; i++) begin
         wq(Q); m_scl = 1'b1; wq(Q); if (sda_pull_low) seen = 1'b1;
         wq(Q); m_scl = 1'b0; wq(Q); if (sda_pull_low) seen = 1'b1;
      end
      chk(!seen, "R12 SDA driven after NACK", {7'h0, seen}, 8'h00);
      chk(d0 == 8'hC0, "R8 read-only value", d0, 8'hC0);
      bus_stop(); wq(2);
      chk(sda_pull_low == 1'b0, "R13 release after STOP", {7'h0, sda_pull_low}, 8'h00);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule